// File: doc/BRIEF.md
# Wireless Module Power-Up Sequencer

This block sits on the host side of a wireless radio module and owns the three control lines that bring the module to life: the enable of the module's I/O supply rail, the module chip-enable, and the module's active-low reset. It watches two power-good indications, one for the battery rail and one for the I/O rail, and a level request from the host that says whether the module should be powered. When the request is raised it walks the module up in a fixed order. First the I/O rail is enabled, and only while the battery is good. Chip-enable follows once the I/O rail reports good. Reset is then released after a crystal-settling delay counted in clock cycles. When the request is dropped it walks the module down. Chip-enable and reset fall together first, and the I/O rail enable follows one cycle later.

The settling delay is a base number of milliseconds plus a host-selected extra margin in whole milliseconds, converted to cycles from a clock-rate parameter given in kHz. The margin is captured at the moment chip-enable rises. The block also polices the rails themselves. If the I/O rail is good without the battery, if the battery fails while the I/O rail enable is on, or if the I/O rail is lost while chip-enable is on, a sticky error flag is set. Any power-up in progress is cut short with the normal shutdown, and no new power-up is allowed until the next reset. Control lines are plain levels; the block has no data stream.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: `io_en` rises only in the cycle after `req_on` and `batt_good` were both high with `seq_err` low. The sequencer then leaves the off state (`state_o` = 0) for the rail-up state (`state_o` = 1). While `batt_good` is low, `req_on` has no effect.
- R2: `chip_en` rises, entering the settle state (`state_o` = 2), only in the cycle after `io_good` was seen high in the rail-up state. While `io_good` stays low, `chip_en` stays low.
- R3: `reset_n_out` rises, entering the run state (`state_o` = 3), exactly (SETTLE_MS + `extra_ms`) × CLK_KHZ cycles after `chip_en` rises. `extra_ms` is captured in the cycle `chip_en` rises, and later changes do not alter the current delay.
- R4: When `req_on` is low in the rail-up, settle or run state, the next cycle has `chip_en` and `reset_n_out` low with `io_en` still high (shutdown state, `state_o` = 4). The cycle after that has `io_en` low and `state_o` = 0.
- R5: `seq_err` is set by any of three conditions: `io_good` high while `batt_good` is low; `io_en` high while `batt_good` is low; `chip_en` high while `io_good` is low. Once set, `seq_err` stays set until `rst_n` is asserted.
- R6: A condition from R5 that occurs in the rail-up, settle or run state forces the R4 shutdown on the next cycle, regardless of `req_on`.
- R7: While `seq_err` is set, the sequencer stays in the off state with all three control outputs low, even with `req_on` and `batt_good` high.
- R8: During and right after reset, `io_en`, `chip_en`, `reset_n_out`, `seq_err` and `state_o` are all 0.
- R9: `io_en`, `chip_en` and `reset_n_out` always carry a definite 0 or 1 out of reset.
- R10: A normal power-down, with the request dropped, then `io_good` removed, then `batt_good` removed, leaves `seq_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| req_on | input | 1 | Host request: high to power the module, low to power it down |
| batt_good | input | 1 | Battery rail power-good |
| io_good | input | 1 | I/O rail power-good |
| extra_ms | input | XMS_W | Extra crystal-settling margin in milliseconds, captured at chip-enable rise |
| io_en | output | 1 | Enable for the module I/O supply rail |
| chip_en | output | 1 | Module chip-enable |
| reset_n_out | output | 1 | Module active-low reset (high = released) |
| state_o | output | 3 | Sequencer state: 0 off, 1 rail-up, 2 settle, 3 run, 4 shutdown |
| seq_err | output | 1 | Sticky supply-ordering error |

## Verification
The hardest case to reach from the ports is a supply fault that lands inside the settle window. This is the only time chip-enable is high while reset is still held. The stimulus raises the I/O rail to start settling and then removes `io_good` a few cycles into the count. The check is that reset never rises, that shutdown follows on the next cycle, and that the lockout then holds against a standing request. The exact settle length is measured by counting sampled low cycles of `reset_n_out` after chip-enable goes high. `extra_ms` is changed in the middle of the wait to show that the captured value governs.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    PS_OFF      = 3'd0,
    PS_RAIL_UP  = 3'd1,
    PS_SETTLE   = 3'd2,
    PS_RUN      = 3'd3,
    PS_SHUTDOWN = 3'd4
  } pseq_state_e;

endpackage

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int CLK_KHZ   = 50000,
  parameter int SETTLE_MS = 5,
  parameter int XMS_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic [XMS_W-1:0] extra_ms,
  output logic             done
);

  localparam int MAX_CYC = (SETTLE_MS + (1 << XMS_W) - 1) * CLK_KHZ;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit_q;
  logic [CW-1:0] limit_calc;

  // target length fixed at the moment chip-enable goes high
  always_comb begin
    limit_calc = CW'((SETTLE_MS + 32'(extra_ms)) * CLK_KHZ);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      limit_q <= '0;
    end else if (start) begin
      cnt_q   <= '0;
      limit_q <= limit_calc;
    end else if (active) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign done = active && (cnt_q == limit_q - CW'(1));

  // R3: the running count never passes the captured target
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q < limit_q));

endmodule

// File: rtl/pwr_rail_guard.sv
module pwr_rail_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic batt_good,
  input  logic io_good,
  input  logic io_en,
  input  logic chip_en,
  output logic fault,
  output logic seq_err
);

  logic err_q;

  // supply ordering violations as seen from the rails and our own drives
  always_comb begin
    fault = (io_good && !batt_good) ||
            (io_en   && !batt_good) ||
            (chip_en && !io_good);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (fault) err_q <= 1'b1;
  end

  assign seq_err = err_q;

  // R5: once raised, the error flag stays raised
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_q) |-> err_q);

  // R5: a fault is always recorded on the next edge
  a_r5_fault_latched: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> err_q);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_on,
  input  logic        batt_good,
  input  logic        io_good,
  input  logic        fault,
  input  logic        seq_err,
  input  logic        settle_done,
  output pseq_state_e state,
  output logic        io_en,
  output logic        chip_en,
  output logic        rel_n,
  output logic        settle_start,
  output logic        settle_active
);

  pseq_state_e state_q, state_d;
  logic        abort;

  assign abort = !req_on || fault;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_OFF:      if (req_on && batt_good && !seq_err && !fault) state_d = PS_RAIL_UP;
      PS_RAIL_UP:  if (abort) state_d = PS_SHUTDOWN;
                   else if (io_good) state_d = PS_SETTLE;
      PS_SETTLE:   if (abort) state_d = PS_SHUTDOWN;
                   else if (settle_done) state_d = PS_RUN;
      PS_RUN:      if (abort) state_d = PS_SHUTDOWN;
      PS_SHUTDOWN: state_d = PS_OFF;
      default:     state_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PS_OFF;
    else state_q <= state_d;
  end

  // outputs decoded from the state register only: always driven, no glitch path from inputs
  always_comb begin
    io_en   = 1'b0;
    chip_en = 1'b0;
    rel_n   = 1'b0;
    unique case (state_q)
      PS_RAIL_UP:  io_en = 1'b1;
      PS_SETTLE:   begin io_en = 1'b1; chip_en = 1'b1; end
      PS_RUN:      begin io_en = 1'b1; chip_en = 1'b1; rel_n = 1'b1; end
      PS_SHUTDOWN: io_en = 1'b1;
      default:     ;
    endcase
  end

  assign state         = state_q;
  assign settle_start  = (state_q == PS_RAIL_UP) && (state_d == PS_SETTLE);
  assign settle_active = (state_q == PS_SETTLE);

  // R1: rail enable only follows a good battery
  a_r1_io_after_batt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_en) |-> $past(batt_good));

  // R2: chip-enable only follows a good I/O rail
  a_r2_en_after_io: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_en) |-> ($past(io_good) && io_en));

  // R4: the rail enable is the last to fall
  a_r4_down_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_en) |-> (!chip_en && !rel_n && $past(!chip_en) && $past(!rel_n)));

  // R6: a fault while powered forces shutdown next cycle
  a_r6_fault_forces_down: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && state_q != PS_OFF && state_q != PS_SHUTDOWN) |=> (state_q == PS_SHUTDOWN));

  // R7: latched error holds the sequencer off
  a_r7_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err && state_q == PS_OFF) |=> (state_q == PS_OFF));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int CLK_KHZ   = 50000,
  parameter int SETTLE_MS = 5,
  parameter int XMS_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_on,
  input  logic             batt_good,
  input  logic             io_good,
  input  logic [XMS_W-1:0] extra_ms,
  output logic             io_en,
  output logic             chip_en,
  output logic             reset_n_out,
  output logic [2:0]       state_o,
  output logic             seq_err
);

  localparam int BASE_CYC = SETTLE_MS * CLK_KHZ;

  pseq_state_e state;
  logic        fault;
  logic        settle_start;
  logic        settle_active;
  logic        settle_done;

  pwr_rail_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .batt_good (batt_good),
    .io_good   (io_good),
    .io_en     (io_en),
    .chip_en   (chip_en),
    .fault     (fault),
    .seq_err   (seq_err)
  );

  pwr_settle_timer #(
    .CLK_KHZ   (CLK_KHZ),
    .SETTLE_MS (SETTLE_MS),
    .XMS_W     (XMS_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (settle_start),
    .active   (settle_active),
    .extra_ms (extra_ms),
    .done     (settle_done)
  );

  pwr_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_on        (req_on),
    .batt_good     (batt_good),
    .io_good       (io_good),
    .fault         (fault),
    .seq_err       (seq_err),
    .settle_done   (settle_done),
    .state         (state),
    .io_en         (io_en),
    .chip_en       (chip_en),
    .rel_n         (reset_n_out),
    .settle_start  (settle_start),
    .settle_active (settle_active)
  );

  assign state_o = state;

  // checker-side age of chip-enable, used only by the settle-gap property
  logic [31:0] ce_age;
  always_ff @(posedge clk) begin
    if (!rst_n || !chip_en) ce_age <= '0;
    else if (ce_age != '1) ce_age <= ce_age + 32'd1;
  end

  // R3: reset release never comes earlier than the base settle time
  a_r3_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n_out) |-> (ce_age >= 32'(BASE_CYC)));

  // R9: control lines are never undefined
  a_r9_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({io_en, chip_en, reset_n_out}));

endmodule

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;

  localparam int KHZ  = 4;
  localparam int SMS  = 5;
  localparam int XW   = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_on, batt_good, io_good;
  logic [XW-1:0] extra_ms;
  logic          io_en, chip_en, reset_n_out, seq_err;
  logic [2:0]    state_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pwr_seq_ctrl #(.CLK_KHZ(KHZ), .SETTLE_MS(SMS), .XMS_W(XW)) uut (
    .clk(clk), .rst_n(rst_n), .req_on(req_on), .batt_good(batt_good),
    .io_good(io_good), .extra_ms(extra_ms), .io_en(io_en), .chip_en(chip_en),
    .reset_n_out(reset_n_out), .state_o(state_o), .seq_err(seq_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_on = 1'b0; batt_good = 1'b0; io_good = 1'b0; extra_ms = '0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  // raise rails and request, return the number of cycles reset stayed low after chip-enable
  task automatic bring_up(input int xms, input int late_xms, output int low_cnt);
    extra_ms = XW'(xms);
    batt_good = 1'b1; req_on = 1'b1;
    step(1);
    chk_eq("R1 io_en after request", int'(io_en), 1);
    io_good = 1'b1;
    step(1);
    chk_eq("R2 chip_en after io_good", int'(chip_en), 1);
    extra_ms = XW'(late_xms);
    low_cnt = 0;
    if (!reset_n_out) low_cnt = 1;
    while (!reset_n_out && low_cnt < 400) begin
      step(1);
      if (!reset_n_out) low_cnt++;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk_eq("R8 io_en reset", int'(io_en), 0);
    chk_eq("R8 chip_en reset", int'(chip_en), 0);
    chk_eq("R8 reset_n_out reset", int'(reset_n_out), 0);
    chk_eq("R8 state reset", int'(state_o), 0);
    chk_eq("R8 seq_err reset", int'(seq_err), 0);
  endtask

  task automatic t_gating();
    do_reset();
    req_on = 1'b1;
    step(3);
    chk_eq("R1 no start without battery", int'(io_en), 0);
    chk_eq("R1 state stays off", int'(state_o), 0);
    batt_good = 1'b1;
    step(1);
    chk_eq("R1 rail-up state", int'(state_o), 1);
    step(5);
    chk_eq("R2 chip_en waits for io_good", int'(chip_en), 0);
    chk_eq("R2 still rail-up", int'(state_o), 1);
    io_good = 1'b1;
    step(1);
    chk_eq("R2 settle state", int'(state_o), 2);
    chk_eq("R2 reset held in settle", int'(reset_n_out), 0);
  endtask

  task automatic t_settle_base();
    int n;
    do_reset();
    bring_up(0, 0, n);
    chk_eq("R3 base settle length", n, SMS * KHZ);
    chk_eq("R3 run state", int'(state_o), 3);
    chk_eq("R9 chip_en defined in run", int'(chip_en), 1);
  endtask

  task automatic t_settle_margin();
    int n;
    do_reset();
    bring_up(3, 15, n);
    chk_eq("R3 settle with captured margin", n, (SMS + 3) * KHZ);
  endtask

  task automatic t_power_down();
    int n;
    do_reset();
    bring_up(0, 0, n);
    req_on = 1'b0;
    step(1);
    chk_eq("R4 chip_en low first", int'(chip_en), 0);
    chk_eq("R4 reset low first", int'(reset_n_out), 0);
    chk_eq("R4 io_en still high", int'(io_en), 1);
    chk_eq("R4 shutdown state", int'(state_o), 4);
    step(1);
    chk_eq("R4 io_en low next", int'(io_en), 0);
    chk_eq("R4 off state", int'(state_o), 0);
    io_good = 1'b0;
    step(2);
    batt_good = 1'b0;
    step(2);
    chk_eq("R10 clean power-down no error", int'(seq_err), 0);
  endtask

  task automatic t_drop_in_settle();
    do_reset();
    batt_good = 1'b1; req_on = 1'b1;
    step(1);
    io_good = 1'b1;
    step(4);
    req_on = 1'b0;
    step(1);
    chk_eq("R4 drop in settle shutdown", int'(state_o), 4);
    chk_eq("R4 drop in settle chip_en", int'(chip_en), 0);
    step(1);
    chk_eq("R4 drop in settle io_en off", int'(io_en), 0);
    chk_eq("R4 reset never released", int'(reset_n_out), 0);
  endtask

  task automatic t_batt_fault();
    int n;
    do_reset();
    bring_up(0, 0, n);
    batt_good = 1'b0;
    step(1);
    chk_eq("R5 battery drop sets error", int'(seq_err), 1);
    chk_eq("R6 battery drop forces shutdown", int'(state_o), 4);
    chk_eq("R6 chip_en cut", int'(chip_en), 0);
    step(1);
    chk_eq("R6 then off", int'(state_o), 0);
    io_good = 1'b0;
    batt_good = 1'b1;
    step(5);
    chk_eq("R7 lockout state", int'(state_o), 0);
    chk_eq("R7 lockout io_en", int'(io_en), 0);
    chk_eq("R5 error still set", int'(seq_err), 1);
    do_reset();
    chk_eq("R5 error cleared by reset", int'(seq_err), 0);
  endtask

  task automatic t_io_loss_in_settle();
    do_reset();
    batt_good = 1'b1; req_on = 1'b1;
    step(1);
    io_good = 1'b1;
    step(3);
    io_good = 1'b0;
    step(1);
    chk_eq("R5 io loss under chip_en sets error", int'(seq_err), 1);
    chk_eq("R6 io loss forces shutdown", int'(state_o), 4);
    step(1);
    chk_eq("R6 io loss reset never released", int'(reset_n_out), 0);
    step(4);
    chk_eq("R7 stays off after io loss", int'(state_o), 0);
  endtask

  task automatic t_io_before_batt();
    do_reset();
    io_good = 1'b1;
    step(1);
    chk_eq("R5 io rail without battery", int'(seq_err), 1);
    chk_eq("R5 off state unchanged", int'(state_o), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_on = 1'b0; batt_good = 1'b0; io_good = 1'b0; extra_ms = '0;
    t_reset_state();
    t_gating();
    t_settle_base();
    t_settle_margin();
    t_power_down();
    t_drop_in_settle();
    t_batt_fault();
    t_io_loss_in_settle();
    t_io_before_batt();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule